// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is the serial front end of a small register-mapped peripheral. It watches an already-synchronised clock and data pair from a two-wire host bus and recognises START and STOP conditions. When a frame carries its own 7-bit address, it acknowledges the frame. The top four address bits are a parameter. The bottom three come from strap inputs, so up to eight copies can share one bus. The first byte of a write is a command byte, and the block keeps it as the selected register number. Later bytes of the same write go to that register through a write strobe. A repeated START followed by the address with the read bit set returns the selected register, most significant bit first.

The register contents live outside the block. The block presents the command byte on a register-select output, samples the read-data input when it loads a byte to send, and pulses a strobe whenever it loads the status register (command 0x03) so the owner can clear it. While the external interrupt request is high, the block also answers reads to the shared alert response address 0001100. It returns its own address and pulses a clear output. It gives way in arbitration when another responder sends a 0 where it sends a 1.

Top module: `smbus_reg_slave`

## Requirements
- R1: A frame whose first byte holds address {ADDR_HI, addr_pins_i} (default ADDR_HI = 4'b0100) is acknowledged by pulling data low during the ninth clock. A frame with any other address gets no acknowledge and causes no strobe.
- R2: A falling data edge while clock is high is a START. A rising data edge while clock is high is a STOP, which returns the block to idle with the data line released. A repeated START after the command byte begins a read of the selected register.
- R3: In a write, the address, the command byte and every data byte are acknowledged. Each data byte raises wr_stb_o for exactly one cycle, with wr_data_o holding the byte and reg_sel_o holding the command.
- R4: A read sends the selected register's rd_data_i value MSB first. It sends another byte when the host acknowledges, and it releases the data line once the host sends a NACK (data high on the ninth clock).
- R5: Each byte loaded from register 0x03 pulses status_rd_o for one cycle. A second byte read from it in the same transaction therefore returns the cleared value.
- R6: A data byte written with command 0x03 is acknowledged but raises no write strobe.
- R7: Commands above LAST_REG (default 0x06) read as 0x00 whatever rd_data_i holds, and writes to them raise no strobe.
- R8: When alert_i is high, a read to address 0001100 is acknowledged and returns the byte {ADDR_HI, addr_pins_i, 0}, and alert_clr_o pulses once. When alert_i is low, that address gets no acknowledge.
- R9: While sending, if the block releases data for a 1 bit and samples the line low, it stops driving for the rest of the byte.
- R10: The data pull-down is only switched on while clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_pins_i | input | 3 | Strapped low address bits |
| alert_i | input | 1 | Interrupt request is asserted |
| alert_clr_o | output | 1 | One-cycle pulse after an alert response |
| reg_sel_o | output | 8 | Selected register (command byte) |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Data for the write strobe |
| rd_data_i | input | 8 | Contents of the selected register |
| status_rd_o | output | 1 | One-cycle pulse when the status register is read |

## Verification
The host side is driven through several patterns. Plain writes and command-then-repeated-START reads show that the command is latched and that acknowledges and data bits are timed correctly. A frame with a foreign address shows that a near-miss is ignored: the register read back afterwards is unchanged. A two-byte status read with ACK then NACK separates one clear strobe per loaded byte from one strobe per transaction. Alert response frames are sent with the interrupt high, with it low, and against a competing responder that holds data low. Together these separate the answer, the silence and the arbitration loss.

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave #(
  parameter logic [3:0] ADDR_HI    = 4'b0100,
  parameter logic [6:0] ARA_ADDR   = 7'b0001100,
  parameter logic [7:0] LAST_REG   = 8'd6,
  parameter logic [7:0] STATUS_REG = 8'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] addr_pins_i,
  input  logic       alert_i,
  output logic       alert_clr_o,
  output logic [7:0] reg_sel_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  input  logic [7:0] rd_data_i,
  output logic       status_rd_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_TX, S_MACK, S_NEXT
  } st_t;

  st_t        st;
  logic       scl_q, sda_q, ara, rw, ack_ph;
  logic [3:0] cnt;
  logic [7:0] sr, cmd;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire last_bit = (cnt == 4'd7);
  wire [7:0] byte_in  = {sr[6:0], sda_i};
  wire [6:0] own_addr = {ADDR_HI, addr_pins_i};
  wire [7:0] rd_val   = (cmd > LAST_REG) ? 8'h00 : rd_data_i;
  wire       wr_ok    = (cmd <= LAST_REG) && (cmd != STATUS_REG);

  assign reg_sel_o = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; cmd <= '0;
      ara <= 1'b0; rw <= 1'b0; ack_ph <= 1'b0;
      sda_pull_o <= 1'b0; wr_stb_o <= 1'b0; wr_data_o <= '0;
      status_rd_o <= 1'b0; alert_clr_o <= 1'b0;
    end else begin
      wr_stb_o    <= 1'b0;
      status_rd_o <= 1'b0;
      alert_clr_o <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 4'd1;
            if (last_bit) begin
              ack_ph <= 1'b0;
              if (byte_in[7:1] == own_addr) begin
                ara <= 1'b0; rw <= byte_in[0]; st <= S_AACK;
              end else if (byte_in == {ARA_ADDR, 1'b1} && alert_i) begin
                ara <= 1'b1; rw <= 1'b1; st <= S_AACK;
              end else
                st <= S_IDLE;
            end
          end
          S_AACK, S_CACK, S_WACK: if (scl_fall) begin
            if (!ack_ph) begin
              sda_pull_o <= 1'b1;
              ack_ph <= 1'b1;
            end else begin
              ack_ph <= 1'b0;
              cnt <= '0;
              if (st == S_AACK && ara) begin
                sr <= {own_addr, 1'b0};
                sda_pull_o <= ~own_addr[6];
                alert_clr_o <= 1'b1;
                st <= S_TX;
              end else if (st == S_AACK && rw) begin
                sr <= rd_val;
                sda_pull_o <= ~rd_val[7];
                status_rd_o <= (cmd == STATUS_REG);
                st <= S_TX;
              end else begin
                sda_pull_o <= 1'b0;
                st <= (st == S_AACK) ? S_CMD : S_WDAT;
              end
            end
          end
          S_CMD: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 4'd1;
            if (last_bit) begin
              cmd <= byte_in;
              st  <= S_CACK;
            end
          end
          S_WDAT: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 4'd1;
            if (last_bit) begin
              wr_stb_o  <= wr_ok;
              wr_data_o <= byte_in;
              st <= S_WACK;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
              if (!sda_pull_o && !sda_i) st <= S_IDLE;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                st <= S_MACK;
              end else begin
                sr <= {sr[6:0], 1'b0};
                sda_pull_o <= ~sr[6];
              end
            end
          end
          S_MACK: if (scl_rise) st <= (sda_i || ara) ? S_IDLE : S_NEXT;
          S_NEXT: if (scl_fall) begin
            sr <= rd_val;
            sda_pull_o <= ~rd_val[7];
            status_rd_o <= (cmd == STATUS_REG);
            cnt <= '0;
            st <= S_TX;
          end
          default: sda_pull_o <= 1'b0;
        endcase
      end
    end
  end

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_o);
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  p_stat_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_o |-> (reg_sel_o == STATUS_REG));
  p_stat_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_o |=> !status_rd_o);
  p_no_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (reg_sel_o != STATUS_REG && reg_sel_o <= LAST_REG));
  p_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr_o |=> !alert_clr_o);
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);
endmodule

// File: tb/smbus_reg_slave_tb_top.sv
module smbus_reg_slave_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1, oth_pull = 1'b0;
  logic [2:0] pins = 3'b101;
  logic       alert = 1'b0;
  logic       sda_pull_o, alert_clr_o, wr_stb_o, status_rd_o;
  logic [7:0] reg_sel_o, wr_data_o, rd_data;
  logic       stat_load = 1'b0;
  logic [7:0] stat_val = 8'h00;
  logic [7:0] rf [0:7];
  wire        line = sda_m & ~sda_pull_o & ~oth_pull;

  int nchk = 0, nbad = 0;

  smbus_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_pull_o(sda_pull_o),
    .addr_pins_i(pins), .alert_i(alert), .alert_clr_o(alert_clr_o),
    .reg_sel_o(reg_sel_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
    .rd_data_i(rd_data), .status_rd_o(status_rd_o));

  assign rd_data = (reg_sel_o < 8'd7) ? rf[reg_sel_o[2:0]] : 8'hA5;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else begin
      if (wr_stb_o) rf[reg_sel_o[2:0]] <= wr_data_o;
      if (status_rd_o) rf[3] <= 8'h00;
      else if (stat_load) rf[3] <= stat_val;
    end
  end

  typedef struct { int kind; int a; int d; string req; } ev_t;
  ev_t expq[$];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_ev(input int kind, input int a, input int d, input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    expq.push_back(e);
  endtask

  task automatic see_ev(input int kind, input int a, input int d);
    ev_t e;
    nchk++;
    if (expq.size() == 0) begin
      nbad++;
      $display("FAIL R1 R6 R7 R8 unexpected event act=%0d/%0h/%0h exp=none", kind, a, d);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.a != a || e.d != d) begin
        nbad++;
        $display("FAIL %s event act=%0d/%0h/%0h exp=%0d/%0h/%0h",
                 e.req, kind, a, d, e.kind, e.a, e.d);
      end
    end
  endtask

  // monitor: 0 = write, 1 = status read, 2 = alert clear
  always @(negedge clk) if (rst_n) begin
    if (wr_stb_o)    see_ev(0, reg_sel_o, wr_data_o);
    if (status_rd_o) see_ev(1, reg_sel_o, 0);
    if (alert_clr_o) see_ev(2, 0, 0);
  end

  task automatic wait_q(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q(); scl = 1'b1; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q(); scl = 1'b1;
    repeat (2) @(negedge clk);
    b = line;
    repeat (2) @(negedge clk);
    scl = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask

  function automatic logic [7:0] dev_byte(input logic r);
    return {4'b0100, pins, r};
  endfunction

  task automatic wr_reg(input logic [7:0] c, input logic [7:0] d, input string req);
    logic ack;
    bus_start();
    put_byte(dev_byte(1'b0), ack); chk({req, " addr ack"}, ack, 1);
    put_byte(c, ack);              chk({req, " cmd ack"}, ack, 1);
    put_byte(d, ack);              chk({req, " data ack"}, ack, 1);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [7:0] v);
    logic ack;
    bus_start();
    put_byte(dev_byte(1'b0), ack);
    put_byte(c, ack);
    bus_start();
    put_byte(dev_byte(1'b1), ack); chk("R2 repeated start read ack", ack, 1);
    get_byte(v, 1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic ack, drove;
    repeat (5) @(negedge clk);
    chk("R2 reset pull released", sda_pull_o, 0);
    chk("R3 reset no strobe", wr_stb_o, 0);
    rst_n = 1'b1;
    wait_q();

    // R3 write then R4 read back
    push_ev(0, 1, 8'h5A, "R3");
    wr_reg(8'h01, 8'h5A, "R3");
    push_ev(0, 2, 8'hC3, "R3");
    wr_reg(8'h02, 8'hC3, "R3");
    rd_reg(8'h01, v);
    chk("R4 read reg1", v, 8'h5A);
    chk("R4 released after nack", sda_pull_o, 0);
    rd_reg(8'h02, v);
    chk("R4 read reg2", v, 8'hC3);

    // R1 foreign address ignored
    bus_start();
    put_byte({4'b0100, 3'b111, 1'b0}, ack); chk("R1 foreign addr nack", ack, 0);
    put_byte(8'h01, ack);
    put_byte(8'hFF, ack);
    bus_stop();
    rd_reg(8'h01, v);
    chk("R1 reg unchanged after foreign frame", v, 8'h5A);

    // R6 write to status discarded
    stat_val = 8'h3C; stat_load = 1'b1; @(negedge clk); stat_load = 1'b0;
    wr_reg(8'h03, 8'hFF, "R6");
    // R5 two-byte status read: 3C then cleared
    push_ev(1, 3, 0, "R5");
    push_ev(1, 3, 0, "R5");
    bus_start();
    put_byte(dev_byte(1'b0), ack);
    put_byte(8'h03, ack);
    bus_start();
    put_byte(dev_byte(1'b1), ack);
    get_byte(v, 1'b0);
    get_byte(v2, 1'b1);
    bus_stop();
    chk("R6 status not overwritten", v, 8'h3C);
    chk("R5 second status byte cleared", v2, 8'h00);

    // R7 out-of-range command
    wr_reg(8'h09, 8'h77, "R7");
    rd_reg(8'h09, v);
    chk("R7 high command reads zero", v, 8'h00);

    // R8 alert response
    alert = 1'b1;
    push_ev(2, 0, 0, "R8");
    bus_start();
    put_byte(8'h19, ack); chk("R8 ara ack", ack, 1);
    get_byte(v, 1'b1);
    bus_stop();
    chk("R8 ara returns own address", v, {4'b0100, 3'b101, 1'b0});
    alert = 1'b0;
    bus_start();
    put_byte(8'h19, ack); chk("R8 ara ignored without alert", ack, 0);
    bus_stop();

    // R9 arbitration loss
    pins = 3'b000; alert = 1'b1;
    push_ev(2, 0, 0, "R8");
    bus_start();
    put_byte(8'h19, ack); chk("R9 ara ack before arbitration", ack, 1);
    oth_pull = 1'b1;
    drove = 1'b0;
    for (int i = 0; i < 8; i++) begin
      get_bit(ack);
      if (i >= 1 && i <= 6 && sda_pull_o) drove = 1'b1;
    end
    oth_pull = 1'b0;
    put_bit(1'b1);
    bus_stop();
    chk("R9 no drive after arbitration loss", drove, 0);
    alert = 1'b0; pins = 3'b101;
    chk("R10 bus released at end", sda_pull_o, 0);

    repeat (10) @(negedge clk);
    while (expq.size() > 0) begin
      ev_t e;
      e = expq.pop_front();
      nchk++; nbad++;
      $display("FAIL %s missing event act=none exp=%0d/%0h/%0h", e.req, e.kind, e.a, e.d);
    end
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule